// File: doc/BRIEF.md
# Interrupt-Vectoring Program Counter Sequencer

This block keeps the 12-bit program counter of a small 8-bit controller and a private four-deep return stack. Each clock it takes one sequencing operation from the instruction decoder: hold, step, jump, call, return, or return-from-interrupt. It also redirects execution to a fixed vector when an interrupt is accepted. The stack holds only return addresses, and software cannot read or write it or its pointer.

There are three interrupt sources: an external pin, a timer-0 overflow and a timer-1 overflow. A request is latched as pending. It is accepted only when its own enable is set, the global enable is set and the stack has a free slot. Accepting a request pushes the address of the next instruction, loads that source's vector, and clears the global enable. A return-from-interrupt sets the global enable again. A request that is blocked stays pending until the conditions allow it.

Top module: `pcseq_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the PC to 0x000, empties the stack, clears all pending requests and clears the global enable, so `stack_full` reads 0.
- R2: The `op` input selects the operation: code 0 holds the PC, code 1 adds one (0xFFF wraps to 0x000), and code 2 loads `target`. Codes 6 and 7 act like code 0.
- R3: Code 3 (call) pushes PC+1 and loads `target`. Code 4 (return) pops the most recent entry into the PC, so returns come back in last-in, first-out order.
- R4: A return (code 4 or 5) on an empty stack advances the PC by one and leaves the stack pointer at zero. A later run of four calls must still be needed to set `stack_full`.
- R5: An accepted interrupt loads the PC with 0x004 for the external source, 0x008 for timer 0 and 0x00C for timer 1. It pushes PC+1, and the decoder operation of that cycle is ignored.
- R6: A source is accepted only when it is pending, its bit in `src_en` is 1, the global enable is 1 and the stack is not full. Otherwise it stays pending. `irq_req` and `src_en` use bit 0 for the external source, bit 1 for timer 0 and bit 2 for timer 1.
- R7: When several eligible sources are pending, the external source wins, then timer 0, then timer 1. Only one source is accepted per cycle.
- R8: Accepting an interrupt clears the global enable. Code 5 (return-from-interrupt) pops like code 4 and sets the global enable. `gie_off` clears it and `gie_on` sets it. When two of these act in the same cycle, acceptance wins over `gie_off`, and `gie_off` wins over `gie_on` and code 5.
- R9: `stack_full` is 1 exactly when four return addresses are stored. A call made while the stack is full still loads `target`, but the return address is dropped.
- R10: A request blocked only by a full stack is accepted in the cycle after a return frees a slot, as long as the global enable is set.
- R11: A request is latched at one clock edge and can be accepted at the next edge at the earliest. A request that arrives in the same cycle as its own source's acceptance stays pending as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Sequencing operation from the decoder |
| target | input | 12 | Jump or call destination |
| irq_req | input | 3 | Interrupt requests: bit 0 external, bit 1 timer 0, bit 2 timer 1 |
| src_en | input | 3 | Per-source interrupt enables, same bit order as `irq_req` |
| gie_on | input | 1 | Set the global interrupt enable |
| gie_off | input | 1 | Clear the global interrupt enable |
| pc | output | 12 | Current program counter |
| stack_full | output | 1 | All four return-stack slots are in use |

## Verification
Every operation code takes effect on `pc` and `stack_full` at the clock edge that samples it. An interrupt request needs two edges: one to latch it as pending and one to accept it. A request blocked by a full stack is accepted one edge after the return that frees the slot. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares both outputs at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pcseq_pkg.sv
// Package: shared operation encoding for the PC sequencer.
// Assumes the decoder drives one 3-bit code per cycle; unlisted codes mean hold.
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_STEP = 3'd1,
        OP_JUMP = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_RETI = 3'd5
    } seq_op_e;
endpackage

// File: rtl/pcseq_irq_arb.sv
// Module: latches interrupt requests, holds the global enable and picks the
// single source to accept this cycle by fixed priority (index 0 highest).
// Assumes stack_full reflects the stack state before this cycle's update.
module pcseq_irq_arb #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic             gie_on,
    input  logic             gie_off,
    input  logic             reti,
    input  logic             stack_full,
    output logic [N_SRC-1:0] grant,
    output logic             gie
);
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] elig;
    logic             taken;

    // Sources that may be accepted right now.
    always_comb begin
        elig = pend & src_en & {N_SRC{gie & ~stack_full}};
    end

    // Fixed-priority pick: lowest index eligible source wins.
    always_comb begin
        grant = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) grant = N_SRC'(1) << i;
        end
    end

    assign taken = |grant;

    // Pending latch: accepted source clears, new request sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~grant) | irq_req;
    end

    // Global enable: acceptance clears, then explicit clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n)               gie <= 1'b0;
        else if (taken)           gie <= 1'b0;
        else if (gie_off)         gie <= 1'b0;
        else if (gie_on || reti)  gie <= 1'b1;
    end
endmodule

// File: rtl/pcseq_ret_stack.sv
// Module: LIFO of return addresses with a saturating pointer.
// Assumes push and pop are never asserted together; a push when full and a
// pop when empty are dropped.
module pcseq_ret_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [W-1:0]                  push_data,
    output logic [W-1:0]                  top_data,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    sp
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign empty  = (sp == '0);
    assign full   = (sp == SP_W'(DEPTH));
    assign wr_idx = IDX_W'(sp);
    assign rd_idx = IDX_W'(sp - 1'b1);
    assign top_data = mem[rd_idx];

    // Pointer: count up on accepted push, down on accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)              sp <= '0;
        else if (push && !full)  sp <= sp + 1'b1;
        else if (pop && !empty)  sp <= sp - 1'b1;
    end

    // Storage: write the slot above the current top on push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_idx] <= push_data;
    end
endmodule

// File: rtl/pcseq_pc_path.sv
// Module: combinational next-PC selection and stack control.
// Assumes grant is one-hot or zero; a grant overrides the decoder operation.
module pcseq_pc_path #(
    parameter int W          = 12,
    parameter int N_SRC      = 3,
    parameter int VEC_STRIDE = 4
) (
    input  logic [W-1:0]     pc,
    input  logic [2:0]       op,
    input  logic [W-1:0]     target,
    input  logic [N_SRC-1:0] grant,
    input  logic [W-1:0]     top_data,
    input  logic             stk_empty,
    output logic [W-1:0]     pc_nxt,
    output logic             push,
    output logic             pop,
    output logic [W-1:0]     push_data
);
    import pcseq_pkg::*;

    logic [W-1:0] pc_inc;
    logic [W-1:0] vec;
    seq_op_e      opc;

    assign pc_inc    = pc + 1'b1;
    assign push_data = pc_inc;
    assign opc       = seq_op_e'(op);

    // Vector address for the granted source: (index+1) * stride.
    always_comb begin
        vec = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) vec = W'((i + 1) * VEC_STRIDE);
        end
    end

    // Next PC and stack request for this cycle.
    always_comb begin
        pc_nxt = pc;
        push   = 1'b0;
        pop    = 1'b0;
        if (|grant) begin
            pc_nxt = vec;
            push   = 1'b1;
        end else begin
            case (opc)
                OP_STEP: pc_nxt = pc_inc;
                OP_JUMP: pc_nxt = target;
                OP_CALL: begin
                    pc_nxt = target;
                    push   = 1'b1;
                end
                OP_RET, OP_RETI: begin
                    pop    = 1'b1;
                    pc_nxt = stk_empty ? pc_inc : top_data;
                end
                default: pc_nxt = pc;
            endcase
        end
    end
endmodule

// File: rtl/pcseq_core.sv
// Module: top of the PC sequencer; holds the PC register and ties together
// the interrupt arbiter, the return stack and the next-PC logic.
// Assumes synchronous active-low reset and one decoder operation per cycle.
module pcseq_core #(
    parameter int PC_W       = 12,
    parameter int STK_DEPTH  = 4,
    parameter int N_SRC      = 3,
    parameter int VEC_STRIDE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [PC_W-1:0]  target,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic             gie_on,
    input  logic             gie_off,
    output logic [PC_W-1:0]  pc,
    output logic             stack_full
);
    import pcseq_pkg::*;
    localparam int SP_W = $clog2(STK_DEPTH + 1);

    logic [N_SRC-1:0] grant;
    logic             gie;
    logic [PC_W-1:0]  pc_nxt;
    logic [PC_W-1:0]  push_data;
    logic [PC_W-1:0]  top_data;
    logic             push;
    logic             pop;
    logic             stk_empty;
    logic [SP_W-1:0]  sp;
    logic             reti;

    assign reti = (op == OP_RETI);

    pcseq_irq_arb #(.N_SRC(N_SRC)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .src_en     (src_en),
        .gie_on     (gie_on),
        .gie_off    (gie_off),
        .reti       (reti),
        .stack_full (stack_full),
        .grant      (grant),
        .gie        (gie)
    );

    pcseq_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) stk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (top_data),
        .empty     (stk_empty),
        .full      (stack_full),
        .sp        (sp)
    );

    pcseq_pc_path #(.W(PC_W), .N_SRC(N_SRC), .VEC_STRIDE(VEC_STRIDE)) path_i (
        .pc        (pc),
        .op        (op),
        .target    (target),
        .grant     (grant),
        .top_data  (top_data),
        .stk_empty (stk_empty),
        .pc_nxt    (pc_nxt),
        .push      (push),
        .pop       (pop),
        .push_data (push_data)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_nxt;
    end
endmodule

// File: rtl/pcseq_core_chk.sv
// Module: temporal checks on the PC sequencer, attached by bind.
// Assumes the default source count of three and vector stride of four.
module pcseq_core_chk #(
    parameter int PC_W      = 12,
    parameter int STK_DEPTH = 4,
    parameter int N_SRC     = 3,
    parameter int SP_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op,
    input logic [PC_W-1:0]  pc,
    input logic             stack_full,
    input logic [N_SRC-1:0] grant,
    input logic             gie,
    input logic [SP_W-1:0]  sp
);
    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> (pc == '0));  // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0 && grant == '0) |=> $stable(pc));  // R2
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 && sp == '0 && grant == '0) |=> (sp == '0));  // R4
    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |=> (pc == PC_W'(4)));  // R5
    AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (!stack_full && gie));  // R6
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R7
    AST_GIE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> !gie);  // R8
    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sp <= SP_W'(STK_DEPTH)));  // R9
endmodule

bind pcseq_core pcseq_core_chk #(
    .PC_W(PC_W), .STK_DEPTH(STK_DEPTH), .N_SRC(N_SRC), .SP_W(SP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .pc         (pc),
    .stack_full (stack_full),
    .grant      (grant),
    .gie        (gie),
    .sp         (sp)
);

// File: tb/pcseq_core_tb_top.sv
`timescale 1ns/1ps
module pcseq_core_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [11:0] target = '0;
    logic [2:0]  irq_req = '0;
    logic [2:0]  src_en = '0;
    logic        gie_on = 1'b0;
    logic        gie_off = 1'b0;
    logic [11:0] pc;
    logic        stack_full;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state.
    int unsigned m_pc = 0;
    int unsigned m_stk[$];
    bit [2:0]    m_pend = '0;
    bit          m_gie = 1'b0;

    always #2.5 clk = ~clk;

    pcseq_core dut_i (
        .clk(clk), .rst_n(rst_n), .op(op), .target(target),
        .irq_req(irq_req), .src_en(src_en), .gie_on(gie_on),
        .gie_off(gie_off), .pc(pc), .stack_full(stack_full)
    );

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        int acc;
        started = 1'b1;
        if (!rst_n) begin
            m_pc = 0; m_stk.delete(); m_pend = '0; m_gie = 1'b0;
        end else begin
            acc = -1;
            if (m_gie && m_stk.size() < DEPTH) begin
                for (int s = 0; s < 3; s++)
                    if (acc < 0 && m_pend[s] && src_en[s]) acc = s;
            end
            for (int s = 0; s < 3; s++)
                m_pend[s] = (m_pend[s] && s != acc) || irq_req[s];
            if (acc >= 0) begin
                m_stk.push_back((m_pc + 1) % 4096);
                m_pc = 4 * (acc + 1);
                m_gie = 1'b0;
            end else begin
                case (op)
                    3'd1: m_pc = (m_pc + 1) % 4096;
                    3'd2: m_pc = target;
                    3'd3: begin
                        if (m_stk.size() < DEPTH) m_stk.push_back((m_pc + 1) % 4096);
                        m_pc = target;
                    end
                    3'd4, 3'd5: begin
                        if (m_stk.size() > 0) m_pc = m_stk.pop_back();
                        else m_pc = (m_pc + 1) % 4096;
                    end
                    default: ;
                endcase
                if (gie_off) m_gie = 1'b0;
                else if (gie_on || op == 3'd5) m_gie = 1'b1;
            end
        end
    end

    // Compare both outputs at every falling edge.
    always @(negedge clk) begin
        if (started) begin
            n_vec += 2;
            if (pc !== 12'(m_pc)) begin
                n_bad++;
                $display("FAIL %s pc actual=%h expected=%h", cur_req, pc, 12'(m_pc));
            end
            if (stack_full !== (m_stk.size() == DEPTH)) begin
                n_bad++;
                $display("FAIL %s stack_full actual=%b expected=%b", cur_req,
                         stack_full, m_stk.size() == DEPTH);
            end
        end
    end

    task automatic drive(input logic [2:0] o, input logic [11:0] t = '0,
                         input logic [2:0] irq = '0);
        op = o; target = t; irq_req = irq;
        @(negedge clk);
        op = 3'd0; irq_req = '0; gie_on = 1'b0; gie_off = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R2";
        drive(3'd1); drive(3'd1); drive(3'd0); drive(3'd6); drive(3'd7);
        drive(3'd2, 12'hFFE); drive(3'd1); drive(3'd1); drive(3'd1);
        cur_req = "R3";
        drive(3'd3, 12'h100); drive(3'd1); drive(3'd3, 12'h200); drive(3'd1);
        drive(3'd4); drive(3'd4);
        cur_req = "R4";
        drive(3'd4); drive(3'd5); drive(3'd4);
        cur_req = "R9";
        for (int i = 0; i < 4; i++) drive(3'd3, 12'(12'h300 + i * 16));
        drive(3'd3, 12'h7A0); drive(3'd1);
        for (int i = 0; i < 4; i++) drive(3'd4);
        cur_req = "R5";
        src_en = 3'b111; gie_on = 1'b1; drive(3'd2, 12'h050);
        drive(3'd1, '0, 3'b001); drive(3'd3, 12'h444); drive(3'd1); drive(3'd5);
        drive(3'd0, '0, 3'b010); drive(3'd2, 12'h123); drive(3'd5);
        drive(3'd0, '0, 3'b100); drive(3'd0); drive(3'd5);
        cur_req = "R7";
        drive(3'd1, '0, 3'b111); drive(3'd1); drive(3'd5); drive(3'd1); drive(3'd5);
        drive(3'd1); drive(3'd5); drive(3'd1);
        cur_req = "R6";
        src_en = 3'b011; drive(3'd1, '0, 3'b100); drive(3'd1); drive(3'd1);
        gie_off = 1'b1; drive(3'd1, '0, 3'b001); drive(3'd1); drive(3'd1);
        src_en = 3'b111; drive(3'd1);
        cur_req = "R8";
        gie_on = 1'b1; gie_off = 1'b1; drive(3'd1); drive(3'd1);
        gie_on = 1'b1; drive(3'd1); drive(3'd5); drive(3'd5); drive(3'd5);
        cur_req = "R10";
        gie_off = 1'b1; drive(3'd0);
        for (int i = 0; i < 4; i++) drive(3'd3, 12'(12'h600 + i * 32));
        gie_on = 1'b1; drive(3'd0, '0, 3'b010); drive(3'd1); drive(3'd1);
        drive(3'd4); drive(3'd1); drive(3'd5);
        for (int i = 0; i < 4; i++) drive(3'd4);
        cur_req = "R11";
        gie_on = 1'b1; drive(3'd0);
        drive(3'd1, '0, 3'b001); drive(3'd1, '0, 3'b001); drive(3'd5); drive(3'd1);
        drive(3'd5); drive(3'd1);
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            src_en  = 3'($urandom_range(0, 7));
            gie_on  = ($urandom_range(0, 5) == 0);
            gie_off = ($urandom_range(0, 9) == 0);
            drive(3'($urandom_range(0, 7)), 12'($urandom_range(0, 4095)),
                  ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd0);
        end
        cur_req = "R1";
        rst_n = 1'b0; drive(3'd1); drive(3'd1); rst_n = 1'b1; drive(3'd0);
        finish_run();
    end
endmodule